// File: doc/BRIEF.md
# Host-Side Strobe Bus Access Master

This block lets on-chip logic reach the internal memory and registers of a slave processor over an asynchronous strobe bus. A single command (address, write data, direction, release flag and a start pulse) starts one access. If the bus is not yet held, the master drives an active-low bus request and chip select. It then waits for the slave's active-low grant, which arrives through a two-flop synchroniser. Only after that does it run the access.

Each access sets up the address (and the write data), then pulls the read or write strobe low. The slave may hold its ready line low to add wait time, and the strobe stays low for as long as it does. When the synchronised ready is seen high again, read data is captured. The strobe rises, the bus is held for a short time, and the strobe recovers before the done pulse. All minimum widths are counted in clock cycles from parameters. A timeout ends an access whose ready never returns. Request and chip select stay low between accesses until a command arrives with the release flag set.

Top module: `hostbus_master`

## Requirements
- R1: After a start from idle with the bus not held, `bus_req_n` and `bus_cs_n` are low and `busy` is high at the first sample after the accepting edge. No strobe goes low until `bus_gnt_n` has been low long enough to pass a two-flop synchroniser. A strobe is only ever low while the grant is held.
- R2: While the request is out and the grant has not been seen, `bus_addr` equals the command address with bit `FORCE_BIT` set to 1.
- R3: The unforced command address is on `bus_addr` at least `T_ASU` cycles before a strobe falls. It stays unchanged while the strobe is low and for `T_DHD` cycles after the strobe rises.
- R4: A strobe stays low for at least max(`T_BLANK`, 1) cycles on a read and max(`T_BLANK`, `T_WRLOW`) cycles on a write. After that it stays low while the synchronised ready is low. Once `bus_rdy` goes high before clock edge k, the strobe is still low after edge k+1 and high after edge k+2.
- R5: On a read, the value on `bus_din` at the moment ready is seen is presented on `rdata` when `done` pulses. `rdata` keeps that value through later writes and timed-out accesses.
- R6: `bus_cs_n` is low whenever a strobe is low. Between accesses made under one grant, the strobes stay high for at least `T_HIGH` cycles.
- R7: `done` is a one-cycle pulse, and `busy` is low in that cycle. A start while `busy` is high is ignored: no second access and no second done follow.
- R8: If ready stays low for `TMO` cycles after the blanking phase, the strobe returns high after exactly max(`T_BLANK`, low width) + `TMO` low cycles. `err` is then 1 at done, and the request stays asserted. The next accepted start clears `err`.
- R9: A command with `cmd_release` = 1 raises `bus_req_n` and `bus_cs_n` once its access finishes. `busy` stays high until the synchronised grant is seen high, and only then does `done` pulse.
- R10: While the bus is held, a new start skips the request. `bus_req_n` stays low, and the strobe is low at the second sample after the start (with setup of one cycle).
- R11: `cmd_write` = 1 uses `bus_wr_n` and `cmd_write` = 0 uses `bus_rd_n`. The two are never low together. `bus_dout_en` is high only for writes, from setup through hold, with `bus_dout` equal to the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Start pulse for one access, taken only when idle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_release | input | 1 | Give the bus back after this access |
| cmd_addr | input | AW | Access address |
| cmd_wdata | input | DW | Write data |
| busy | output | 1 | High in every state except idle |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last access timed out |
| rdata | output | DW | Last read data |
| bus_req_n | output | 1 | Active-low bus request |
| bus_gnt_n | input | 1 | Active-low bus grant from the slave (asynchronous) |
| bus_cs_n | output | 1 | Active-low chip select |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_addr | output | AW | Bus address |
| bus_dout | output | DW | Write data to the bus |
| bus_dout_en | output | 1 | Write data drive enable |
| bus_din | input | DW | Read data from the bus |
| bus_rdy | input | 1 | Slave ready; low stretches the access (asynchronous) |

## Verification
The hardest case to reach from the ports is the exact timing of the strobe release relative to ready. The release path runs through a synchroniser and a blanking phase, so it is observable only if the slave holds ready low at the right moment. The bench's slave model pulls ready low at the first sample that shows the strobe low, before the blanking phase ends. It then raises ready a chosen number of cycles later and checks the strobe on the two following samples. The timeout and the ignored start are reached from the same held-ready state: ready is never raised, or a second start pulse is injected while the strobe waits.

// File: rtl/hbm_pkg.sv
package hbm_pkg;

  typedef enum logic [2:0] {
    S_IDLE       = 3'd0,
    S_REQ        = 3'd1,
    S_WAIT_GRANT = 3'd2,
    S_SETUP      = 3'd3,
    S_STROBE     = 3'd4,
    S_WAIT_READY = 3'd5,
    S_HOLD       = 3'd6,
    S_RECOVER    = 3'd7
  } hbm_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Cycles spent in a timed phase; never below one.
  function automatic int phase_len(input hbm_state_e s, input logic wr,
                                   input int asu, input int dsu, input int wrlow,
                                   input int blank, input int dhd, input int high,
                                   input int tmo);
    int n;
    case (s)
      S_SETUP:      n = wr ? max2(asu, dsu) : asu;
      S_STROBE:     n = wr ? max2(wrlow, blank) : blank;
      S_WAIT_READY: n = tmo;
      S_HOLD:       n = dhd;
      S_RECOVER:    n = high;
      default:      n = 1;
    endcase
    return max2(n, 1);
  endfunction

endpackage

// File: rtl/hbm_sync.sv
module hbm_sync #(
  parameter int  W       = 1,
  parameter bit  RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage1, stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= {W{RST_VAL}};
      stage2 <= {W{RST_VAL}};
    end else begin
      stage1 <= d_async;
      stage2 <= stage1;
    end
  end

  assign q_sync = stage2;
endmodule

// File: rtl/hbm_phase_timer.sv
module hbm_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= load_val;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/hostbus_master.sv
module hostbus_master
  import hbm_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int FORCE_BIT = AW - 1,
  parameter int T_ASU     = 1,
  parameter int T_DSU     = 1,
  parameter int T_DHD     = 1,
  parameter int T_HIGH    = 1,
  parameter int T_WRLOW   = 1,
  parameter int T_BLANK   = 3,
  parameter int TMO       = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic          cmd_write,
  input  logic          cmd_release,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [DW-1:0] rdata,
  output logic          bus_req_n,
  input  logic          bus_gnt_n,
  output logic          bus_cs_n,
  output logic          bus_rd_n,
  output logic          bus_wr_n,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dout,
  output logic          bus_dout_en,
  input  logic [DW-1:0] bus_din,
  input  logic          bus_rdy
);

  localparam int MAXLEN = max2(max2(max2(T_ASU, T_DSU), max2(T_DHD, T_HIGH)),
                               max2(max2(T_WRLOW, T_BLANK), TMO));
  localparam int CW      = max2($clog2(MAXLEN + 1), 1);
  localparam int MIN_LOW = phase_len(S_STROBE, 1'b0, T_ASU, T_DSU, T_WRLOW,
                                     T_BLANK, T_DHD, T_HIGH, TMO);
  localparam logic [AW-1:0] FORCE_MASK = AW'(1) << FORCE_BIT;

  hbm_state_e st, nx;
  logic held_q, dropping_q, rel_q, wr_q, err_q, done_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;

  // Named internal events
  logic gnt_sync_n, rdy_sync;
  logic gnt_seen, rdy_seen;
  logic t_zero, t_load;
  logic [CW-1:0] t_val;
  logic accept, tmo_evt, drop_go, grant_evt, rd_capture;
  logic strobe_on, pre_grant, req_on, wr_eff;

  hbm_sync #(.W(1), .RST_VAL(1'b1)) u_gnt_sync (
    .clk(clk), .rst_n(rst_n), .d_async(bus_gnt_n), .q_sync(gnt_sync_n));

  hbm_sync #(.W(1), .RST_VAL(1'b1)) u_rdy_sync (
    .clk(clk), .rst_n(rst_n), .d_async(bus_rdy), .q_sync(rdy_sync));

  assign gnt_seen = ~gnt_sync_n;
  assign rdy_seen = rdy_sync;

  hbm_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .zero(t_zero));

  // Next-state logic
  always_comb begin
    nx      = st;
    accept  = 1'b0;
    tmo_evt = 1'b0;
    drop_go = 1'b0;
    case (st)
      S_IDLE: if (cmd_start) begin
        accept = 1'b1;
        nx     = held_q ? S_SETUP : S_REQ;
      end
      S_REQ:        nx = S_WAIT_GRANT;
      S_WAIT_GRANT: if (gnt_seen) nx = S_SETUP;
      S_SETUP:      if (t_zero) nx = S_STROBE;
      S_STROBE:     if (t_zero) nx = S_WAIT_READY;
      S_WAIT_READY: begin
        if (rdy_seen) nx = S_HOLD;
        else if (t_zero) begin
          nx      = S_HOLD;
          tmo_evt = 1'b1;
        end
      end
      S_HOLD:       if (t_zero) nx = S_RECOVER;
      S_RECOVER: begin
        if (dropping_q) begin
          if (!gnt_seen) nx = S_IDLE;
        end else if (t_zero) begin
          if (rel_q) drop_go = 1'b1;
          else       nx = S_IDLE;
        end
      end
      default: nx = S_IDLE;
    endcase
  end

  assign wr_eff     = accept ? cmd_write : wr_q;
  assign t_load     = (nx != st);
  assign t_val      = CW'(phase_len(nx, wr_eff, T_ASU, T_DSU, T_WRLOW, T_BLANK,
                                    T_DHD, T_HIGH, TMO) - 1);
  assign grant_evt  = (st == S_WAIT_GRANT) && gnt_seen;
  assign rd_capture = (st == S_WAIT_READY) && rdy_seen && !wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      held_q     <= 1'b0;
      dropping_q <= 1'b0;
      rel_q      <= 1'b0;
      wr_q       <= 1'b0;
      err_q      <= 1'b0;
      done_q     <= 1'b0;
      addr_q     <= '0;
      wdata_q    <= '0;
      rdata_q    <= '0;
    end else begin
      st     <= nx;
      done_q <= (st == S_RECOVER) && (nx == S_IDLE);
      if (accept) begin
        wr_q    <= cmd_write;
        rel_q   <= cmd_release;
        addr_q  <= cmd_addr;
        wdata_q <= cmd_wdata;
        err_q   <= 1'b0;
      end
      if (grant_evt)  held_q <= 1'b1;
      if (drop_go) begin
        held_q     <= 1'b0;
        dropping_q <= 1'b1;
      end else if ((st == S_RECOVER) && dropping_q && !gnt_seen) begin
        dropping_q <= 1'b0;
      end
      if (tmo_evt)    err_q   <= 1'b1;
      if (rd_capture) rdata_q <= bus_din;
    end
  end

  // Bus outputs decoded from the state register
  assign pre_grant   = (st == S_REQ) || (st == S_WAIT_GRANT);
  assign req_on      = pre_grant || held_q;
  assign strobe_on   = (st == S_STROBE) || (st == S_WAIT_READY);
  assign bus_req_n   = ~req_on;
  assign bus_cs_n    = ~req_on;
  assign bus_rd_n    = ~(strobe_on && !wr_q);
  assign bus_wr_n    = ~(strobe_on && wr_q);
  assign bus_addr    = pre_grant ? (addr_q | FORCE_MASK) : addr_q;
  assign bus_dout    = wdata_q;
  assign bus_dout_en = wr_q && ((st == S_SETUP) || strobe_on || (st == S_HOLD));
  assign busy        = (st != S_IDLE);
  assign done        = done_q;
  assign err         = err_q;
  assign rdata       = rdata_q;

  // Strobe low-run counter kept for the width assertion
  logic [CW-1:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          low_run <= '0;
    else if (!strobe_on)                 low_run <= '0;
    else if (low_run < CW'(MIN_LOW))     low_run <= low_run + 1'b1;
  end

  AST_STROBE_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_on |-> (held_q && gnt_seen)); // R1
  AST_FORCED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_req_n && !held_q) |-> bus_addr[FORCE_BIT]); // R2
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_on && $past(strobe_on)) |-> $stable(bus_addr)); // R3
  AST_WAIT_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_WAIT_READY) && !rdy_seen && !t_zero) |=> strobe_on); // R4
  AST_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_on && $past(strobe_on)) |-> ($past(low_run) >= CW'(MIN_LOW - 1))); // R4
  AST_CS_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n || !bus_wr_n) |-> !bus_cs_n); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7
  AST_TMO_KEEPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> (err && !bus_req_n)); // R8
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n)); // R11

endmodule

// File: tb/test_hostbus_master.sv
`timescale 1ns/1ps
module test_hostbus_master;
  localparam int AW = 16, DW = 16, FB = 15;
  localparam int TMO = 20, BLANK = 3, DHD = 1, HIGH = 1, GDLY = 2;
  localparam logic [AW-1:0] FMASK = 16'h8000;

  logic clk = 0, rst_n = 0;
  logic cmd_start = 0, cmd_write = 0, cmd_release = 0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic busy, done, err;
  logic [DW-1:0] rdata;
  logic bus_req_n, bus_cs_n, bus_rd_n, bus_wr_n, bus_dout_en;
  logic bus_gnt_n = 1'b1, bus_rdy = 1'b1;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_dout, bus_din = '0;

  int checks = 0, fails = 0, done_cnt = 0, glow = 0;
  logic [AW-1:0] cur_addr = '0;
  logic [DW-1:0] cur_wdata = '0, prev_rd = '0;
  logic cur_wr = 0;

  always #2 clk = ~clk;

  hostbus_master #(.AW(AW), .DW(DW), .FORCE_BIT(FB), .T_BLANK(BLANK),
                   .T_DHD(DHD), .T_HIGH(HIGH), .TMO(TMO)) i_hostbus_master (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_write(cmd_write),
    .cmd_release(cmd_release), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .busy(busy), .done(done), .err(err), .rdata(rdata),
    .bus_req_n(bus_req_n), .bus_gnt_n(bus_gnt_n), .bus_cs_n(bus_cs_n),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_dout_en(bus_dout_en), .bus_din(bus_din),
    .bus_rdy(bus_rdy));

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit strb();
    return !bus_rd_n || !bus_wr_n;
  endfunction

  // Slave grant model: follows the request after GDLY cycles
  initial begin
    int gc = 0;
    forever begin
      @(posedge clk); #1;
      if (bus_gnt_n != bus_req_n) begin
        gc++;
        if (gc >= GDLY) begin bus_gnt_n = bus_req_n; gc = 0; end
      end else gc = 0;
    end
  end

  // Per-clock protocol reference model
  initial begin
    bit was_low = 0, had_rise = 0;
    int hold_left = 0, high_run = 0;
    logic [AW-1:0] prev_addr = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        glow = bus_gnt_n ? 0 : glow + 1;
        chk(!(!bus_rd_n && !bus_wr_n), "R11 both strobes", {bus_rd_n, bus_wr_n}, 2'b11);
        if (!cur_wr) chk(!bus_dout_en, "R11 dout_en on read", bus_dout_en, 0);
        if (!bus_req_n && bus_gnt_n)
          chk(bus_addr == (cur_addr | FMASK), "R2 forced address", bus_addr, cur_addr | FMASK);
        if (strb()) begin
          chk(glow >= 2, "R1 strobe before grant", glow, 2);
          chk(!bus_cs_n, "R6 cs with strobe", bus_cs_n, 0);
          chk(bus_addr == cur_addr, "R3 address under strobe", bus_addr, cur_addr);
          if (cur_wr) chk(bus_dout_en && bus_dout == cur_wdata, "R11 write data", bus_dout, cur_wdata);
          if (!was_low) begin
            chk(prev_addr == cur_addr, "R3 address setup", prev_addr, cur_addr);
            if (had_rise) chk(high_run >= HIGH, "R6 high width", high_run, HIGH);
          end
          high_run = 0;
        end else begin
          if (was_low) begin hold_left = DHD; had_rise = 1; end
          if (hold_left > 0) begin
            chk(bus_addr == cur_addr, "R3 address hold", bus_addr, cur_addr);
            if (cur_wr) chk(bus_dout_en, "R11 dout_en in hold", bus_dout_en, 1);
            hold_left--;
          end
          high_run++;
        end
        if (bus_req_n) had_rise = 0;
        if (done) begin
          chk(!busy, "R7 busy at done", busy, 0);
          done_cnt++;
        end
        was_low = strb();
        prev_addr = bus_addr;
      end
    end
  end

  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        input bit rel, input int waitc, input logic [DW-1:0] rv,
                        input bit tmo, input bit held, input bit inject);
    int n, d0;
    bit saw_drop = 0;
    @(negedge clk);
    cur_addr = a; cur_wdata = wd; cur_wr = wr; bus_rdy = 1; d0 = done_cnt;
    @(negedge clk);
    cmd_write = wr; cmd_addr = a; cmd_wdata = wd; cmd_release = rel; cmd_start = 1;
    @(posedge clk); @(negedge clk);
    cmd_start = 0;
    if (held) begin
      chk(!strb() && !bus_req_n, "R10 setup under held grant", {strb(), bus_req_n}, 0);
      @(posedge clk); @(negedge clk);
      chk(strb(), "R10 strobe two samples after start", strb(), 1);
    end else begin
      chk(busy && !bus_req_n && !bus_cs_n, "R1 request out", {busy, bus_req_n, bus_cs_n}, 3'b100);
      chk(!strb(), "R1 no strobe before grant", strb(), 0);
    end
    n = 0;
    while (!strb() && n < 200) begin @(negedge clk); n++; end
    chk(wr ? !bus_wr_n : !bus_rd_n, "R11 strobe select", {bus_rd_n, bus_wr_n}, wr ? 2'b10 : 2'b01);
    bus_din = rv;
    if (tmo) begin
      bus_rdy = 0; n = 0;
      while (strb()) begin n++; @(negedge clk); end
      chk(n == BLANK + TMO, "R8 timeout low length", n, BLANK + TMO);
      bus_rdy = 1;
    end else if (waitc > 0) begin
      bus_rdy = 0;
      if (inject) begin
        cmd_start = 1; cmd_addr = ~a; cmd_write = ~wr;
        @(negedge clk); cmd_start = 0;
        repeat (waitc - 1) @(negedge clk);
      end else repeat (waitc) @(negedge clk);
      chk(strb(), "R4 strobe held while not ready", strb(), 1);
      bus_rdy = 1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      chk(strb(), "R4 strobe low after k+1", strb(), 1);
      @(posedge clk); @(negedge clk);
      chk(!strb(), "R4 strobe high after k+2", strb(), 0);
    end else begin
      while (strb()) @(negedge clk);
    end
    bus_din = ~rv;
    n = 0;
    while (!done && n < 500) begin
      if (bus_req_n && busy) saw_drop = 1;
      @(negedge clk); n++;
    end
    chk(done, "R7 done pulse", done, 1);
    if (!wr && !tmo) begin
      chk(rdata == rv, "R5 read data", rdata, rv);
      prev_rd = rv;
    end else chk(rdata == prev_rd, "R5 rdata kept", rdata, prev_rd);
    chk(err == tmo, "R8 error flag", err, tmo);
    if (tmo) chk(!bus_req_n, "R8 request kept", bus_req_n, 0);
    if (rel) begin
      chk(bus_req_n && bus_cs_n && bus_gnt_n, "R9 released", {bus_req_n, bus_cs_n, bus_gnt_n}, 3'b111);
      chk(saw_drop, "R9 busy while grant drops", saw_drop, 1);
    end else chk(!bus_req_n, "R10 request held", bus_req_n, 0);
    repeat (3) begin
      @(negedge clk);
      chk(!busy && !done, "R7 no further access", {busy, done}, 0);
    end
    chk(done_cnt == d0 + 1, "R7 single done", done_cnt, d0 + 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && bus_req_n && bus_cs_n && bus_rd_n && bus_wr_n && !bus_dout_en,
        "R1 reset state", {busy, done, err, bus_req_n, bus_cs_n, bus_rd_n, bus_wr_n}, 7'b0001111);
    rst_n = 1;
    repeat (2) @(negedge clk);
    access(0, 16'h1234, 16'h0,    0, 4, 16'hA5A5, 0, 0, 0);
    access(1, 16'h0042, 16'hBEEF, 0, 3, 16'h0,    0, 1, 1);
    access(0, 16'h0100, 16'h0,    0, 0, 16'h5A5A, 0, 1, 0);
    access(0, 16'h0200, 16'h0,    0, 0, 16'h7777, 1, 1, 0);
    access(1, 16'h0300, 16'hC0DE, 1, 2, 16'h0,    0, 1, 0);
    access(0, 16'h4321, 16'h0,    1, 5, 16'h1357, 0, 0, 0);
    access(1, 16'h0055, 16'h9999, 0, 1, 16'h0,    0, 0, 0);
    access(0, 16'h0066, 16'h0,    1, 2, 16'h2468, 0, 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule